// File: doc/BRIEF.md
# Static Chip Test Stimulus Sequencer

This block runs a static, truth-table style check of a small digital chip on a bench fixture. An operator flips a mode input between SETUP and TEST. Six pushbuttons set the logic levels applied to the chip. Six response lines from the chip drive six indicator lamps. A slow internal clock, with three selectable rates, can take the place of the first stimulus line. The same clock can step a decimal counter whose 4-bit code is fed to a seven-segment decoder under test.

The sequencer enforces power-before-signal ordering. On entry to TEST, the supply enable for the chip rises first, and stimulus follows one cycle later. On exit, stimulus drops first and the supply follows one cycle later. In SETUP, every line toward the socket is held low.

Buttons pass through a two-flop synchronizer and a debounce filter before they reach a stimulus line. The rate divider picks up a new rate only at its next terminal count, so a rate change never produces a short clock phase.

Top module: `chip_stim_seq`

## Requirements
- R1: After synchronous reset, `dut_pwr`, `stim`, `lamp`, `bcd`, `seg_all_on` and `seg_all_off` are all 0.
- R2: While in SETUP (test_mode low for two or more consecutive edges), `dut_pwr`, `stim`, `lamp`, `bcd` and both segment checks are 0, whatever the buttons, responses and other controls do.
- R3: At the first edge that samples `test_mode` high, `dut_pwr` goes to 1 while `stim` stays 0. Stimulus becomes live from the following edge. `stim` is never nonzero unless `dut_pwr` was already 1 one cycle earlier.
- R4: At the first edge that samples `test_mode` low, `stim` goes to 0 and `dut_pwr` stays 1. `dut_pwr` falls at the next edge.
- R5: A pressed button (btn bit = 1) drives its stimulus line to 1 and a released button drives it to 0. A button passes through two synchronizer flops and must then differ from its filtered value for DB_CYCLES consecutive cycles before the filtered value changes, so shorter glitches have no effect on `stim`.
- R6: With `clk_en` = 1, stimulus line 0 (`stim[0]`) carries the internal clock instead of button 0. Lines 1 to 5 still follow their buttons.
- R7: `rate_sel` 0, 1 and 2 make the internal clock toggle every SYS_HZ/2, SYS_HZ/6 and SYS_HZ/20 cycles (1, 3 and 10 Hz). Code 3 acts the same as code 2.
- R8: A change on `rate_sel` takes effect only at the next terminal count of the divider, so the half period in progress completes at the old length.
- R9: In TEST, `lamp[i]` shows `resp[i]` registered one cycle. Outside TEST, every lamp is dark (0).
- R10: In TEST with `dec_mode` = 1, `bcd` advances by one on each rising edge of the internal clock through 0..9 and wraps from 9 to 0. With `dec_mode` = 0 it holds its value. Outside TEST it is cleared to 0.
- R11: In TEST with `dec_mode` = 1, `lamp_chk` raises `seg_all_on` and `blank_chk` raises `seg_all_off`. `lamp_chk` takes priority, so the two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (SYS_HZ) |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | 1 = TEST, 0 = SETUP |
| dec_mode | input | 1 | Seven-segment decoder test mode |
| clk_en | input | 1 | Internal clock replaces stimulus line 0 |
| rate_sel | input | 2 | Internal clock rate: 0 slow, 1 medium, 2/3 fast |
| btn | input | NL | Raw pushbuttons, 1 = pressed |
| lamp_chk | input | 1 | Request all-segments-on check |
| blank_chk | input | 1 | Request all-segments-off check |
| resp | input | NL | Response lines from the chip |
| dut_pwr | output | 1 | Supply enable for the chip |
| stim | output | NL | Stimulus lines to the chip |
| lamp | output | NL | Indicator lamps, 1 = lit |
| bcd | output | 4 | Decimal code for decoder test |
| seg_all_on | output | 1 | All-segments-on check active |
| seg_all_off | output | 1 | All-segments-off check active |

## Verification
The bench builds the block with SYS_HZ = 120 and DB_CYCLES = 5. This gives half periods of 60, 20 and 6 cycles. At these values, every rate, several rate changes at terminal counts, more than one full 0..9 wrap of the decimal counter, and debounce glitches both shorter and longer than the filter window all fit within a few thousand cycles. A behavioural model of the power sequencing, filter, divider and counter is compared against every output on every cycle. Directed checks add measured toggle intervals and the entry and exit ordering.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [1:0] {
    ST_SETUP = 2'd0,
    ST_PWR   = 2'd1,
    ST_TEST  = 2'd2,
    ST_DRAIN = 2'd3
  } seq_state_t;
endpackage

// File: rtl/csq_debounce.sv
module csq_debounce #(
  parameter int DB_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  localparam int DW = $clog2(DB_CYCLES + 1);
  localparam logic [DW-1:0] DB_LAST = DW'(DB_CYCLES - 1);

  logic s1_q, s2_q;
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      cnt_q <= '0;
      clean <= 1'b0;
    end else begin
      s1_q <= raw;
      s2_q <= s1_q;
      if (s2_q != clean) begin
        if (cnt_q == DB_LAST) begin
          clean <= s2_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  // R5: the filtered value only ever moves to the synchronized level
  a_r5_follow_sync: assert property (@(posedge clk) disable iff (rst)
    !$stable(clean) |-> (clean == $past(s2_q)));
endmodule

// File: rtl/csq_rate_div.sv
module csq_rate_div #(
  parameter int SYS_HZ = 1000000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate_sel,
  output logic       div_clk,
  output logic       rise_pulse
);
  localparam int H_SLOW = SYS_HZ / 2;
  localparam int H_MED  = SYS_HZ / 6;
  localparam int H_FAST = SYS_HZ / 20;
  localparam int CW     = $clog2(H_SLOW + 1);
  localparam logic [CW-1:0] L_SLOW = CW'(H_SLOW - 1);
  localparam logic [CW-1:0] L_MED  = CW'(H_MED - 1);
  localparam logic [CW-1:0] L_FAST = CW'(H_FAST - 1);

  logic [CW-1:0] cnt_q, lim_q, lim_req;

  always_comb begin
    case (rate_sel)
      2'd0:    lim_req = L_SLOW;
      2'd1:    lim_req = L_MED;
      default: lim_req = L_FAST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      lim_q      <= L_SLOW;
      div_clk    <= 1'b0;
      rise_pulse <= 1'b0;
    end else if (cnt_q == lim_q) begin
      cnt_q      <= '0;
      lim_q      <= lim_req;
      div_clk    <= ~div_clk;
      rise_pulse <= ~div_clk;
    end else begin
      cnt_q      <= cnt_q + 1'b1;
      rise_pulse <= 1'b0;
    end
  end

  // R8: a new rate is taken only where a half period starts
  a_r8_swap_at_terminal: assert property (@(posedge clk) disable iff (rst)
    !$stable(lim_q) |-> (cnt_q == '0));
  // R7: counter stays inside the current half period
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= lim_q);
  // R10: a rise pulse lasts one cycle
  a_r10_rise_single: assert property (@(posedge clk) disable iff (rst)
    rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/csq_bcd.sv
module csq_bcd (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       adv,
  output logic [3:0] bcd
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      bcd <= 4'd0;
    end else if (adv) begin
      bcd <= (bcd == 4'd9) ? 4'd0 : bcd + 4'd1;
    end
  end

  // R10: code stays decimal
  a_r10_range: assert property (@(posedge clk) disable iff (rst)
    bcd <= 4'd9);
endmodule

// File: rtl/chip_stim_seq.sv
module chip_stim_seq #(
  parameter int NL        = 6,
  parameter int SYS_HZ    = 1000000,
  parameter int DB_CYCLES = 10000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          test_mode,
  input  logic          dec_mode,
  input  logic          clk_en,
  input  logic [1:0]    rate_sel,
  input  logic [NL-1:0] btn,
  input  logic          lamp_chk,
  input  logic          blank_chk,
  input  logic [NL-1:0] resp,
  output logic          dut_pwr,
  output logic [NL-1:0] stim,
  output logic [NL-1:0] lamp,
  output logic [3:0]    bcd,
  output logic          seg_all_on,
  output logic          seg_all_off
);
  import csq_pkg::*;

  logic [NL-1:0] btn_clean, line_val;
  logic          div_clk, rise_pulse;
  seq_state_t    st_q, st_nxt;
  logic          live_nxt;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    csq_debounce #(.DB_CYCLES(DB_CYCLES)) u_db (
      .clk(clk), .rst(rst), .raw(btn[i]), .clean(btn_clean[i]));
  end

  csq_rate_div #(.SYS_HZ(SYS_HZ)) u_div (
    .clk(clk), .rst(rst), .rate_sel(rate_sel),
    .div_clk(div_clk), .rise_pulse(rise_pulse));

  always_comb begin
    case (st_q)
      ST_SETUP: st_nxt = test_mode ? ST_PWR : ST_SETUP;
      ST_PWR:   st_nxt = test_mode ? ST_TEST : ST_DRAIN;
      ST_TEST:  st_nxt = test_mode ? ST_TEST : ST_DRAIN;
      default:  st_nxt = ST_SETUP;
    endcase
    live_nxt = (st_nxt == ST_TEST);
    line_val = btn_clean;
    if (clk_en) line_val[0] = div_clk;
  end

  csq_bcd u_bcd (
    .clk(clk), .rst(rst), .clear(!live_nxt),
    .adv(dec_mode && rise_pulse), .bcd(bcd));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_SETUP;
      dut_pwr     <= 1'b0;
      stim        <= '0;
      lamp        <= '0;
      seg_all_on  <= 1'b0;
      seg_all_off <= 1'b0;
    end else begin
      st_q        <= st_nxt;
      dut_pwr     <= (st_nxt != ST_SETUP);
      stim        <= live_nxt ? line_val : '0;
      lamp        <= live_nxt ? resp : '0;
      seg_all_on  <= live_nxt && dec_mode && lamp_chk;
      seg_all_off <= live_nxt && dec_mode && blank_chk && !lamp_chk;
    end
  end

  // R3: no stimulus unless power was already on
  a_r3_power_first: assert property (@(posedge clk) disable iff (rst)
    (stim != '0) |-> $past(dut_pwr));
  // R4: leaving TEST drops stimulus at the first edge
  a_r4_stim_drop: assert property (@(posedge clk) disable iff (rst)
    !test_mode |=> (stim == '0));
  // R2: two edges of SETUP leave the supply off
  a_r2_setup_unpowered: assert property (@(posedge clk) disable iff (rst)
    (!test_mode && $past(!test_mode)) |=> !dut_pwr);
  // R9: lamps dark without power
  a_r9_dark_unpowered: assert property (@(posedge clk) disable iff (rst)
    !dut_pwr |-> (lamp == '0));
  // R11: the two segment checks exclude each other
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(seg_all_on && seg_all_off));
endmodule

// File: tb/chip_stim_seq_tb_top.sv
module chip_stim_seq_tb_top;
  localparam int NL = 6;
  localparam int SYS_HZ = 120;
  localparam int DB = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic test_mode = 0, dec_mode = 0, clk_en = 0, lamp_chk = 0, blank_chk = 0;
  logic [1:0] rate_sel = 2'd0;
  logic [NL-1:0] btn = '0, resp = '0;
  logic dut_pwr, seg_all_on, seg_all_off;
  logic [NL-1:0] stim, lamp;
  logic [3:0] bcd;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chip_stim_seq #(.NL(NL), .SYS_HZ(SYS_HZ), .DB_CYCLES(DB)) dut_i (
    .clk(clk), .rst(rst), .test_mode(test_mode), .dec_mode(dec_mode),
    .clk_en(clk_en), .rate_sel(rate_sel), .btn(btn), .lamp_chk(lamp_chk),
    .blank_chk(blank_chk), .resp(resp), .dut_pwr(dut_pwr), .stim(stim),
    .lamp(lamp), .bcd(bcd), .seg_all_on(seg_all_on), .seg_all_off(seg_all_off));

  // ---------------- behavioural reference model ----------------
  int m_st, m_cnt, m_lim, m_bcd;
  bit m_dclk, m_rise, m_pwr, m_on, m_off;
  bit [NL-1:0] m_stim, m_lamp, m_s1, m_s2, m_db;
  int m_dbc [NL];

  function automatic int half_of(input logic [1:0] r);
    if (r == 2'd0) return SYS_HZ / 2;
    if (r == 2'd1) return SYS_HZ / 6;
    return SYS_HZ / 20;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_lim = SYS_HZ / 2; m_bcd = 0;
      m_dclk = 0; m_rise = 0; m_pwr = 0; m_on = 0; m_off = 0;
      m_stim = '0; m_lamp = '0; m_s1 = '0; m_s2 = '0; m_db = '0;
      foreach (m_dbc[i]) m_dbc[i] = 0;
    end else begin
      int nx;
      bit live;
      bit [NL-1:0] line;
      // mode sequencing: 0 setup, 1 powering, 2 test, 3 draining
      if (m_st == 0) nx = test_mode ? 1 : 0;
      else if (m_st == 3) nx = 0;
      else nx = test_mode ? 2 : 3;
      live = (nx == 2);
      line = m_db;
      if (clk_en) line[0] = m_dclk;
      if (!live) m_bcd = 0;
      else if (dec_mode && m_rise) m_bcd = (m_bcd == 9) ? 0 : m_bcd + 1;
      m_pwr = (nx != 0);
      m_stim = live ? line : '0;
      m_lamp = live ? resp : '0;
      m_on = live && dec_mode && lamp_chk;
      m_off = live && dec_mode && blank_chk && !lamp_chk;
      m_st = nx;
      // internal clock
      if (m_cnt == m_lim - 1) begin
        m_cnt = 0; m_rise = !m_dclk; m_dclk = !m_dclk; m_lim = half_of(rate_sel);
      end else begin
        m_cnt++; m_rise = 0;
      end
      // button filters
      for (int i = 0; i < NL; i++) begin
        if (m_s2[i] != m_db[i]) begin
          if (m_dbc[i] == DB - 1) begin m_db[i] = m_s2[i]; m_dbc[i] = 0; end
          else m_dbc[i]++;
        end else m_dbc[i] = 0;
      end
      m_s2 = m_s1;
      m_s1 = btn;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(dut_pwr == m_pwr, "R3 R4 model dut_pwr", dut_pwr, m_pwr);
      chk(stim == m_stim, "R5 R6 model stim", stim, m_stim);
      chk(lamp == m_lamp, "R9 model lamp", lamp, m_lamp);
      chk(bcd == m_bcd[3:0], "R10 model bcd", bcd, m_bcd);
      chk(seg_all_on == m_on, "R11 model seg_all_on", seg_all_on, m_on);
      chk(seg_all_off == m_off, "R11 model seg_all_off", seg_all_off, m_off);
    end
  end

  // ---------------- directed sequence ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(output int len);
    logic p;
    p = stim[0];
    len = 0;
    while (stim[0] == p && len < 300) begin
      cyc(1);
      len++;
    end
  endtask

  initial begin
    int len;
    bit wrap_seen;
    int top;
    logic [3:0] held;
    cyc(4);
    rst = 1'b0;
    cyc(1);
    chk({dut_pwr, stim, lamp, bcd, seg_all_on, seg_all_off} == '0, "R1 reset state",
        {dut_pwr, stim, lamp}, 0);

    btn = '1; resp = '1; dec_mode = 1; lamp_chk = 1; clk_en = 1;
    cyc(30);
    chk({dut_pwr, stim, lamp, bcd, seg_all_on} == '0, "R2 setup quiet",
        {dut_pwr, stim, lamp}, 0);

    btn = 6'b101010; clk_en = 0; dec_mode = 0; lamp_chk = 0; resp = '0;
    cyc(20);
    test_mode = 1;
    cyc(1);
    chk(dut_pwr == 1'b1, "R3 power first", dut_pwr, 1);
    chk(stim == '0, "R3 stimulus held", stim, 0);
    cyc(1);
    chk(stim == 6'b101010, "R3 stimulus live", stim, 6'b101010);

    btn[0] = 1'b1; cyc(2); btn[0] = 1'b0;
    cyc(15);
    chk(stim == 6'b101010, "R5 glitch ignored", stim, 6'b101010);
    btn[0] = 1'b1;
    cyc(12);
    chk(stim == 6'b101011, "R5 press accepted", stim, 6'b101011);

    resp = 6'b010011;
    cyc(2);
    chk(lamp == 6'b010011, "R9 lamps follow", lamp, 6'b010011);

    clk_en = 1; rate_sel = 2'd2;
    cyc(3);
    measure(len);
    measure(len);
    chk(len == SYS_HZ / 20, "R7 fast rate", len, SYS_HZ / 20);
    rate_sel = 2'd1;
    measure(len);
    chk(len == SYS_HZ / 20, "R8 old period completes", len, SYS_HZ / 20);
    measure(len);
    chk(len == SYS_HZ / 6, "R7 medium rate", len, SYS_HZ / 6);
    rate_sel = 2'd0;
    measure(len);
    chk(len == SYS_HZ / 6, "R8 old period completes", len, SYS_HZ / 6);
    measure(len);
    chk(len == SYS_HZ / 2, "R7 slow rate", len, SYS_HZ / 2);
    rate_sel = 2'd3;
    measure(len);
    measure(len);
    chk(len == SYS_HZ / 20, "R7 code 3 fast", len, SYS_HZ / 20);
    chk(stim[5:1] == 5'b10101, "R6 other lines keep buttons", stim[5:1], 5'b10101);

    btn[0] = 1'b0;
    clk_en = 0;
    cyc(12);
    chk(stim[0] == 1'b0, "R6 line 0 back to button", stim[0], 0);

    dec_mode = 1;
    wrap_seen = 0; top = 0;
    for (int k = 0; k < 160; k++) begin
      held = bcd;
      cyc(1);
      if (held == 4'd9 && bcd == 4'd0) wrap_seen = 1;
      if (bcd > top) top = bcd;
    end
    chk(wrap_seen, "R10 wraps 9 to 0", wrap_seen, 1);
    chk(top == 9, "R10 reaches 9", top, 9);
    dec_mode = 0;
    cyc(2);
    held = bcd;
    cyc(40);
    chk(bcd == held, "R10 holds without decoder mode", bcd, held);

    dec_mode = 1; lamp_chk = 1; blank_chk = 1;
    cyc(2);
    chk(seg_all_on && !seg_all_off, "R11 all-on priority", {seg_all_on, seg_all_off}, 2);
    lamp_chk = 0;
    cyc(2);
    chk(!seg_all_on && seg_all_off, "R11 all-off", {seg_all_on, seg_all_off}, 1);

    test_mode = 0;
    cyc(1);
    chk(stim == '0, "R4 stimulus drops first", stim, 0);
    chk(dut_pwr == 1'b1, "R4 power still on", dut_pwr, 1);
    cyc(1);
    chk(dut_pwr == 1'b0, "R4 power drops next", dut_pwr, 0);
    chk({lamp, bcd, seg_all_off} == '0, "R2 back to ground", {lamp, bcd}, 0);
    cyc(5);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule